// File: doc/BRIEF.md
# Fractional Cache Clock Ratio Generator

This block produces the clock for a secondary cache interface from a reference clock that runs at twice the processor core rate. A 3-bit ratio code selects a core-to-cache divide of 1, 1.5, 2, 2.5, 3, 3.5 or 4. All timing is counted in reference cycles, which are half core periods, so the half-integer ratios need no second clock edge. The all-zeros code stops the generated clock and tells the downstream delay-locked loop to stay off.

The code is taken in only while the clock is stopped. While a nonzero code is running, other nonzero codes on the input are ignored, and the only way to change ratio is to stop with code 000 first. Besides the divided clock, the block gives a single-cycle strobe that marks each rising edge of the divided clock, a delay-locked-loop enable, and a configuration error flag. The error flag is raised when the selected cache period is longer than the system bus period supplied on a separate input. All pins are plain control or status signals, with no streaming handshake.

Top module: `cache_clk_ratio_gen`

## Requirements
- R1: After reset, `div_clk_o`, `rise_stb_o`, `dll_en_o` and `cfg_err_o` are all 0.
- R2: When `ratio_code_i` is 000 at a rising reference edge, `div_clk_o`, `rise_stb_o` and `dll_en_o` are 0 after that edge, and they stay 0 while the code stays 000.
- R3: Code 001 gives an output period of 2 reference cycles (divide 1). Code 010 gives 3 cycles (divide 1.5). Code 011 gives 7 cycles (divide 3.5).
- R4: Code 100 gives an output period of 4 reference cycles (divide 2). Code 101 gives 5 cycles (divide 2.5). Code 110 gives 6 cycles (divide 3). Code 111 gives 8 cycles (divide 4).
- R5: Within each period P, the high phase lasts ceil(P/2) reference cycles and the low phase lasts floor(P/2), so odd periods are high one cycle longer.
- R6: A nonzero code sampled at an edge while stopped sets `dll_en_o` to 1 after that edge. `div_clk_o` starts its first high phase in that same cycle.
- R7: `rise_stb_o` is 1 for exactly the first reference cycle of every high phase of `div_clk_o`, and 0 at all other times.
- R8: While running, a change of `ratio_code_i` to another nonzero value has no effect on the period or the duty of `div_clk_o`.
- R9: `cfg_err_o` is 1 when the clock is running and the selected period in reference cycles exceeds `bus_half_i`. `bus_half_i` is the core-to-bus ratio in half-core units. Otherwise `cfg_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at twice the core rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code_i | input | 3 | Ratio code; 000 stops the clock |
| bus_half_i | input | BUS_W | Core-to-bus ratio in half-core units |
| div_clk_o | output | 1 | Generated cache-interface clock |
| rise_stb_o | output | 1 | One-cycle strobe at each rising edge of div_clk_o |
| dll_en_o | output | 1 | Delay-locked-loop enable, high while running |
| cfg_err_o | output | 1 | Cache clock slower than bus clock |

## Verification
Each of the seven nonzero codes is started from the stopped state, and the clock and strobe are compared cycle by cycle over two full periods. This separates the period lengths and also the uneven duty of the odd periods. A running clock is then given a different nonzero code to show that the period holds. It is then stopped with 000 to show the clock parks low and the enable drops. The error flag is tried with a bus ratio just below and exactly at the selected period, which marks the strict greater-than boundary.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  typedef logic [CODE_W-1:0] ratio_code_t;
  typedef logic [CNT_W-1:0]  ref_cnt_t;

  // Output period, counted in reference (half core) cycles
  function automatic ref_cnt_t period_of(ratio_code_t c);
    case (c)
      3'd1:    period_of = 4'd2;
      3'd2:    period_of = 4'd3;
      3'd3:    period_of = 4'd7;
      3'd4:    period_of = 4'd4;
      3'd5:    period_of = 4'd5;
      3'd6:    period_of = 4'd6;
      3'd7:    period_of = 4'd8;
      default: period_of = 4'd0;
    endcase
  endfunction

  // High phase length: odd periods keep the extra cycle high
  function automatic ref_cnt_t high_of(ref_cnt_t p);
    high_of = ref_cnt_t'((p + 4'd1) >> 1);
  endfunction
endpackage

// File: rtl/cclk_code_hold.sv
module cclk_code_hold
  import cclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ratio_code_t code_i,
  output ratio_code_t code_nxt,
  output ratio_code_t code_q
);
  always_comb begin
    if (code_i == '0)      code_nxt = '0;      // stop always wins
    else if (code_q == '0) code_nxt = code_i;  // sample only while stopped
    else                   code_nxt = code_q;  // running: hold
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  // R8: a nonzero input while running leaves the held code alone
  p_hold_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0 && code_i != '0) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/cclk_phase_gen.sv
module cclk_phase_gen
  import cclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ratio_code_t code_nxt,
  input  ratio_code_t code_q,
  output logic        div_clk_o,
  output logic        rise_stb_o
);
  ref_cnt_t cnt_q;
  ref_cnt_t cnt_inc;
  ref_cnt_t per;
  ref_cnt_t hi_len;

  assign per     = period_of(code_nxt);
  assign hi_len  = high_of(per);
  assign cnt_inc = (cnt_q == per - 4'd1) ? '0 : cnt_q + 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || code_nxt == '0) begin
      cnt_q      <= '0;
      div_clk_o  <= 1'b0;
      rise_stb_o <= 1'b0;
    end else if (code_q == '0) begin
      cnt_q      <= '0;
      div_clk_o  <= 1'b1;
      rise_stb_o <= 1'b1;
    end else begin
      cnt_q      <= cnt_inc;
      div_clk_o  <= (cnt_inc < hi_len);
      rise_stb_o <= (cnt_inc == '0);
    end
  end

  // R2: a stop code parks the clock low on the next cycle
  p_stop_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_nxt == '0) |=> (!div_clk_o && !rise_stb_o));

  // R7: the strobe only marks a low-to-high change of the clock
  p_rise_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |-> (div_clk_o && !$past(div_clk_o)));

  // R5: the phase counter never leaves its period
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0) |-> (cnt_q < period_of(code_q)));
endmodule

// File: rtl/cclk_bus_check.sv
module cclk_bus_check
  import cclk_pkg::*;
#(
  parameter int BUS_W = 4
) (
  input  ratio_code_t      code_q,
  input  logic [BUS_W-1:0] bus_half_i,
  output logic             err_o
);
  localparam int CMP_W = (BUS_W > CNT_W) ? BUS_W : CNT_W;

  logic [CMP_W-1:0] per_w;
  logic [CMP_W-1:0] bus_w;

  assign per_w = CMP_W'(period_of(code_q));
  assign bus_w = CMP_W'(bus_half_i);
  assign err_o = (code_q != '0) && (per_w > bus_w);
endmodule

// File: rtl/cache_clk_ratio_gen.sv
module cache_clk_ratio_gen
  import cclk_pkg::*;
#(
  parameter int BUS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ratio_code_i,
  input  logic [BUS_W-1:0] bus_half_i,
  output logic             div_clk_o,
  output logic             rise_stb_o,
  output logic             dll_en_o,
  output logic             cfg_err_o
);
  ratio_code_t code_nxt;
  ratio_code_t code_q;

  cclk_code_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_i   (ratio_code_i),
    .code_nxt (code_nxt),
    .code_q   (code_q)
  );

  cclk_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_nxt   (code_nxt),
    .code_q     (code_q),
    .div_clk_o  (div_clk_o),
    .rise_stb_o (rise_stb_o)
  );

  cclk_bus_check #(.BUS_W(BUS_W)) u_bus (
    .code_q     (code_q),
    .bus_half_i (bus_half_i),
    .err_o      (cfg_err_o)
  );

  assign dll_en_o = (code_q != '0);

  // R6: the clock only toggles while the loop enable is up
  p_clk_needs_dll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_clk_o |-> dll_en_o);

  // R9: the error flag is never raised while stopped
  p_err_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> dll_en_o);
endmodule

// File: tb/cache_clk_ratio_gen_tb.sv
module cache_clk_ratio_gen_tb;
  localparam int BUS_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       ratio_code_i = 3'd0;
  logic [BUS_W-1:0] bus_half_i = 4'd15;
  logic             div_clk_o, rise_stb_o, dll_en_o, cfg_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cache_clk_ratio_gen #(.BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ratio_code_i(ratio_code_i),
    .bus_half_i(bus_half_i), .div_clk_o(div_clk_o),
    .rise_stb_o(rise_stb_o), .dll_en_o(dll_en_o), .cfg_err_o(cfg_err_o)
  );

  // Periods taken from R3 and R4
  function automatic int exp_period(int c);
    case (c)
      1: return 2;  2: return 3;  3: return 7;
      4: return 4;  5: return 5;  6: return 6;
      7: return 8;  default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare clock and strobe over two periods, starting at the first high cycle
  task automatic watch_periods(int p, string req);
    int hi = (p + 1) / 2;
    int bad_i = -1;
    int act = 0, exp = 0;
    for (int i = 0; i < 2 * p; i++) begin
      int ph = i % p;
      if (bad_i < 0 && (div_clk_o !== (ph < hi) || rise_stb_o !== (ph == 0))) begin
        bad_i = i;
        act = {30'd0, div_clk_o, rise_stb_o};
        exp = {30'd0, (ph < hi), (ph == 0)};
      end
      @(negedge clk);
    end
    check(bad_i < 0, req, act, exp);
  endtask

  task automatic start_code(int c);
    @(negedge clk);
    ratio_code_i = 3'(c);
    @(negedge clk);
  endtask

  task automatic stop_clock();
    ratio_code_i = 3'd0;
    @(negedge clk);
    check(!div_clk_o && !rise_stb_o && !dll_en_o, "R2 stop",
          {29'd0, div_clk_o, rise_stb_o, dll_en_o}, 0);
    repeat (5) @(negedge clk);
    check(!div_clk_o && !dll_en_o, "R2 stays stopped",
          {30'd0, div_clk_o, dll_en_o}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!div_clk_o && !rise_stb_o && !dll_en_o && !cfg_err_o, "R1 reset",
          {28'd0, div_clk_o, rise_stb_o, dll_en_o, cfg_err_o}, 0);
  endtask

  task automatic t_ratio(int c);
    string req = (c <= 3) ? "R3/R5/R7 period" : "R4/R5/R7 period";
    start_code(c);
    check(dll_en_o === 1'b1, "R6 enable on start", int'(dll_en_o), 1);
    watch_periods(exp_period(c), req);
    stop_clock();
  endtask

  task automatic t_ignore_change();
    start_code(4);
    watch_periods(4, "R8 before change");
    ratio_code_i = 3'd7;
    watch_periods(4, "R8 after change");
    check(dll_en_o === 1'b1, "R8 still running", int'(dll_en_o), 1);
    stop_clock();
  endtask

  task automatic t_bus_err();
    bus_half_i = 4'd6;
    start_code(7);
    check(cfg_err_o === 1'b1, "R9 period 8 over bus 6", int'(cfg_err_o), 1);
    bus_half_i = 4'd8;
    @(negedge clk);
    check(cfg_err_o === 1'b0, "R9 period 8 at bus 8", int'(cfg_err_o), 0);
    bus_half_i = 4'd2;
    ratio_code_i = 3'd0;
    @(negedge clk);
    check(cfg_err_o === 1'b0, "R9 no error while stopped", int'(cfg_err_o), 0);
    bus_half_i = 4'd15;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    for (int c = 1; c < 8; c++) t_ratio(c);
    t_ignore_change();
    t_bus_err();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule